// File: doc/BRIEF.md
# GPIO Bank Data and Direction Port

This block is the register-mapped data path of one bank of general-purpose pins. It holds an output latch, a direction register and a reset-tolerance register. It also samples the pad inputs through a synchronizer. Each pin's output enable and output level come straight from its direction bit and its latch bit.

Software reads the value register to see the pad level as it was sampled, even on pins driven as outputs. Because of the synchronizer, a read issued just after a write can still show the old level. A separate read-only address returns the latch contents exactly.

The bank has two resets. A power-on reset clears everything. A synchronous controller reset returns every pin to a released input with latch 0, except the pins whose tolerance bit is set. Those pins keep both their latch and direction bits, so their output survives a soft reset of the controller.

Top module: `gpio_bank`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the latch, direction and tolerance registers are all zero, so `pad_oe_o` = 0, `pad_out_o` = 0, and reads of words 1, 2 and 3 return 0.
- R2: A selected write (`sel_i`=1, `we_i`=1) to word 0 loads the output latch. From the next clock edge on, `pad_out_o` equals the written data.
- R3: A read of word 0 returns `pad_in_i` as it was two rising edges earlier, through a two-flop synchronizer. After only one edge the previous level is still returned. This holds for pins set as outputs as well.
- R4: A selected write to word 1 (byte offset +4 from the value register) loads the direction register, where bit = 1 means output. From the next edge, `pad_oe_o` equals that register, and reading word 1 returns it.
- R5: Reading word 2 returns the output latch. Writes to word 2 change no register: `pad_out_o`, `pad_oe_o` and the word 2 readback all stay the same.
- R6: A selected write to word 3 loads the tolerance register, and reading word 3 returns it.
- R7: On a clock edge with `ctrl_rst_i`=1, every latch and direction bit whose tolerance bit is 0 is cleared. Bits whose tolerance bit is 1 keep their value, and the tolerance register is left unchanged.
- R8: A bus write on the same edge as `ctrl_rst_i`=1 is discarded for all registers.
- R9: When `sel_i`=0, `we_i` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ctrl_rst_i | input | 1 | Synchronous controller (soft) reset, honours the tolerance bits |
| sel_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable, valid with `sel_i` |
| addr_i | input | 2 | Word index: 0 value, 1 direction, 2 latch readback, 3 tolerance |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| pad_oe_o | output | 32 | Per-pin output enable |
| pad_out_o | output | 32 | Per-pin output level |

## Verification
Register writes and the controller reset take effect at the clock edge that samples them, and both pad outputs and readbacks are compared half a cycle after that edge. Read data is combinational from `addr_i`, so a read is sampled a short delay after the address is driven at a falling edge. A pad change is due at the value register after exactly two rising edges. The bench drives it at a falling edge, requires the old level shortly after the first edge, and requires the new level after the second edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    REG_VALUE = 2'd0,
    REG_DIR   = 2'd1,
    REG_RB    = 2'd2,
    REG_TOL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_rst_i,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] tol_o
);
  logic [WIDTH-1:0] latch_q, dir_q, tol_q;

  // soft reset wins over a coincident bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
      tol_q   <= '0;
    end else if (ctrl_rst_i) begin
      latch_q <= latch_q & tol_q;
      dir_q   <= dir_q & tol_q;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        REG_VALUE: latch_q <= wdata_i;
        REG_DIR:   dir_q   <= wdata_i;
        REG_TOL:   tol_q   <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign tol_o   = tol_q;
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  reg_sel_e         rd_sel_i,
  input  logic [WIDTH-1:0] pad_sync_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] tol_i,
  output logic [WIDTH-1:0] rdata_o
);
  always_comb begin
    unique case (rd_sel_i)
      REG_VALUE: rdata_o = pad_sync_i;
      REG_DIR:   rdata_o = dir_i;
      REG_RB:    rdata_o = latch_i;
      REG_TOL:   rdata_o = tol_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_rst_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_out_o
);
  logic [WIDTH-1:0] pad_sync, latch_q, dir_q, tol_q;
  reg_sel_e         reg_sel;
  logic             wr_en;

  assign reg_sel = reg_sel_e'(addr_i[1:0]);
  assign wr_en   = sel_i & we_i;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  gpio_bank_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_rst_i (ctrl_rst_i),
    .wr_en_i    (wr_en),
    .wr_sel_i   (reg_sel),
    .wdata_i    (wdata_i),
    .latch_o    (latch_q),
    .dir_o      (dir_q),
    .tol_o      (tol_q)
  );

  gpio_bank_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .rd_sel_i   (reg_sel),
    .pad_sync_i (pad_sync),
    .latch_i    (latch_q),
    .dir_i      (dir_q),
    .tol_i      (tol_q),
    .rdata_o    (rdata_o)
  );

  assign pad_oe_o  = dir_q;
  assign pad_out_o = latch_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_rst_i,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_in_i,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [WIDTH-1:0]  pad_out_o,
  input logic [WIDTH-1:0]  tol_q
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            up_cnt <= '0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_oe_o == '0 && pad_out_o == '0 && tol_q == '0));

  assert_latch_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 2'd0 && !ctrl_rst_i) |=> pad_out_o == $past(wdata_i));

  assert_sync_delay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 2'd2 && addr_i == 2'd0) |-> rdata_o == $past(pad_in_i, 2));

  assert_dir_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 2'd1 && !ctrl_rst_i) |=> pad_oe_o == $past(wdata_i));

  assert_rb_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 2'd2 && !ctrl_rst_i) |=>
      ($stable(pad_out_o) && $stable(pad_oe_o) && $stable(tol_q)));

  assert_soft_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> (((pad_out_o | pad_oe_o) & ~tol_q) == '0 && $stable(tol_q)));

  assert_no_write_in_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> ((pad_out_o & ~$past(pad_out_o)) == '0 &&
                    (pad_oe_o & ~$past(pad_oe_o)) == '0));

  assert_unselected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !ctrl_rst_i) |=> ($stable(pad_out_o) && $stable(pad_oe_o) && $stable(tol_q)));
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_rst_i (ctrl_rst_i),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pad_in_i   (pad_in_i),
  .pad_oe_o   (pad_oe_o),
  .pad_out_o  (pad_out_o),
  .tol_q      (tol_q)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_rst_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pad_in_i = '0;
  logic [31:0] pad_oe_o;
  logic [31:0] pad_out_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  gpio_bank u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_rst_i(ctrl_rst_i), .sel_i(sel_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d,
                           input logic sel = 1'b1, input logic crst = 1'b0);
    @(negedge clk_i);
    sel_i = sel; we_i = 1'b1; addr_i = a; wdata_i = d; ctrl_rst_i = crst;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0; ctrl_rst_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    check("R1 pad_oe", pad_oe_o, 32'h0);
    check("R1 pad_out", pad_out_o, 32'h0);
    for (int i = 1; i < 4; i++) begin
      bus_read(2'(i), d);
      check("R1 reg read", d, 32'h0);
    end
  endtask

  task automatic t_latch;
    logic [31:0] d;
    bus_write(2'd0, 32'hA5A5_0F0F);
    check("R2 pad_out after write", pad_out_o, 32'hA5A5_0F0F);
    bus_read(2'd2, d);
    check("R5 readback", d, 32'hA5A5_0F0F);
    bus_write(2'd2, 32'hFFFF_FFFF);
    check("R5 pad_out after rb write", pad_out_o, 32'hA5A5_0F0F);
    bus_read(2'd2, d);
    check("R5 readback after rb write", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    bus_write(2'd1, 32'h0000_FFFF);
    check("R4 pad_oe", pad_oe_o, 32'h0000_FFFF);
    bus_read(2'd1, d);
    check("R4 dir read", d, 32'h0000_FFFF);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk_i);
    addr_i = 2'd0;
    pad_in_i = 32'h1234_5678;
    @(posedge clk_i); #5;
    check("R3 old level after one edge", rdata_o, 32'h0);
    @(posedge clk_i); #5;
    check("R3 new level after two edges", rdata_o, 32'h1234_5678);
    // output pins still report the pad, not the latch
    bus_read(2'd0, d);
    check("R3 output pins show pad", d & 32'h0000_FFFF, 32'h0000_5678);
  endtask

  task automatic t_tol_and_soft_reset;
    logic [31:0] d;
    bus_write(2'd3, 32'h00FF_00FF);
    bus_read(2'd3, d);
    check("R6 tol read", d, 32'h00FF_00FF);
    @(negedge clk_i);
    ctrl_rst_i = 1'b1;
    @(negedge clk_i);
    ctrl_rst_i = 1'b0;
    check("R7 latch kept on tolerant pins", pad_out_o, 32'h00A5_000F);
    check("R7 dir kept on tolerant pins", pad_oe_o, 32'h0000_00FF);
    bus_read(2'd3, d);
    check("R7 tol unchanged", d, 32'h00FF_00FF);
    bus_write(2'd0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    check("R8 write discarded in soft reset", pad_out_o, 32'h00A5_000F);
    bus_write(2'd3, 32'h0, 1'b1, 1'b1);
    bus_read(2'd3, d);
    check("R8 tol write discarded", d, 32'h00FF_00FF);
  endtask

  task automatic t_unselected;
    bus_write(2'd1, 32'hFFFF_0000, 1'b0);
    check("R9 dir unchanged without select", pad_oe_o, 32'h0000_00FF);
    bus_write(2'd0, 32'h0, 1'b0);
    check("R9 latch unchanged without select", pad_out_o, 32'h00A5_000F);
  endtask

  task automatic t_power_on;
    logic [31:0] d;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 oe cleared in reset", pad_oe_o, 32'h0);
    check("R1 out cleared in reset", pad_out_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(2'd3, d);
    check("R1 tol cleared by power-on", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_state();
    t_latch();
    t_dir();
    t_sync();
    t_tol_and_soft_reset();
    t_unselected();
    t_power_on();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule